// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers 25 interrupt requests into one pending bit per source and presents a single winner, with its vector address, to the processor. Sources 0 to 2 form a non-maskable group: software trap, illegal-opcode trap and watchdog. Sources 3 to 24 are maskable, and each has an enable bit and a 2-bit programmable level. Maskable sources need both the global enable flag and their own enable bit before they are offered. The winner is chosen first by programmed level and then, among equal levels, by a fixed order in which the lower source number wins.

The processor takes the offered interrupt by pulsing `ack_i`. That clears the source's pending bit and the global enable, and pushes the previous enable and in-service ceiling onto a small nesting stack. `reti_i` pops that stack. A maskable request can only nest over a running handler of a lower level. Non-maskable requests are always offered ahead of maskable ones, even while a non-maskable handler runs. A control bit moves every vector from the 0xFFxx page to the 0x01xx page. A second control bit, set at reset, turns watchdog requests into a reset request instead of an interrupt.

Top module: `prio_vic`

## Requirements
- R1: A source whose `irq_i` bit is high at a clock edge has its pending bit set from that edge on, and `irq_req_o` is only high for a pending source. The pending bit stays set until that source is accepted.
- R2: Maskable source k (`irq_src_o` = 3+k) is offered only when the global enable is 1 and enable bit k is 1. The global enable is written at select 0, bit 0. The enable bits are written at select 1, bit k.
- R3: Maskable level k is written at select 2 (k < 16) or select 3 (k >= 16), in bits [2*(k mod 16)+1 : 2*(k mod 16)]. Among eligible maskable sources the highest level wins, and on equal level the lowest k wins.
- R4: Any pending non-maskable source (0 = software trap, 1 = illegal opcode, 2 = watchdog) is offered before every maskable source, whatever the enables and the in-service level. Among these the lowest number wins.
- R5: The vector is 0xFFFC for sources 0 and 1, 0xFFF8 for source 2, and 0xFFF6 - 2*k for maskable k. When the relocation bit (select 4, bit 0) is 1, the upper byte becomes 0x01.
- R6: `ack_i` while `irq_req_o` is high clears the offered source's pending bit and the global enable. If that source's `irq_i` bit is high in the same cycle, the pending bit stays set.
- R7: After a maskable source of level L is accepted, a maskable source is offered only if its level exceeds L. While a non-maskable handler runs, no maskable source is offered.
- R8: `reti_i` with a non-empty stack, and no acceptance in that cycle, restores the global enable and the in-service level to their values just before the matching acceptance.
- R9: While the watchdog select bit (select 4, bit 1) is 1, `wdt_reset_o` equals `irq_i[2]` and a watchdog request sets no pending bit. While it is 0, `wdt_reset_o` is low and the request latches as source 2.
- R10: After reset no request is offered, `wdt_reset_o` is low, and all enables, levels and relocation are 0. The watchdog select bit is 1.
- R11: With 4 accepted and not yet returned interrupts, `irq_req_o` stays low until a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 25 | Request inputs, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select |
| wr_data_i | input | 32 | Register write data |
| ack_i | input | 1 | Processor accepts the offered interrupt |
| reti_i | input | 1 | Return from interrupt |
| irq_req_o | output | 1 | An interrupt is offered |
| irq_src_o | output | 5 | Offered source number |
| irq_vec_o | output | 16 | Vector address of the offered source |
| wdt_reset_o | output | 1 | Watchdog request routed to reset |

## Verification
The assertions watch, on every cycle, the relations that need no history beyond one cycle. These are: an offered source is pending, and a maskable offer implies the global enable, no pending non-maskable source and no running non-maskable handler. Acceptance clears the enable and the pending bit. A return shrinks the stack by one. A full stack offers nothing. Level ordering among maskable sources, exact vector values under relocation, and the restoration of enable and level through two nested returns are only shown by the bench scenarios, checked against its reference model.

// File: rtl/prio_vic_pkg.sv
package prio_vic_pkg;
  localparam int SEL_MASTER = 0;
  localparam int SEL_ENABLE = 1;
  localparam int SEL_LVL0   = 2;
  localparam int VEC_W      = 16;
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/prio_vic_regs.sv
module prio_vic_regs
  import prio_vic_pkg::*;
#(
  parameter int N_MSK  = 22,
  parameter int LVL_W  = 2,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [SEL_W-1:0]       wr_sel_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  output logic [N_MSK-1:0]       en_o,
  output logic [N_MSK*LVL_W-1:0] lvl_o,
  output logic                   reloc_o,
  output logic                   wdt_sel_o
);
  localparam int PER_WORD  = DATA_W / LVL_W;
  localparam int LVL_WORDS = (N_MSK + PER_WORD - 1) / PER_WORD;
  localparam int SEL_CTRL  = SEL_LVL0 + LVL_WORDS;

  logic [N_MSK-1:0] en_q;
  logic [LVL_W-1:0] lvl_q [N_MSK];
  logic             reloc_q, wdt_sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= '0;
      reloc_q   <= 1'b0;
      wdt_sel_q <= 1'b1;
    end else if (wr_en_i) begin
      if (wr_sel_i == SEL_W'(SEL_ENABLE)) en_q <= wr_data_i[N_MSK-1:0];
      if (wr_sel_i == SEL_W'(SEL_CTRL)) begin
        reloc_q   <= wr_data_i[0];
        wdt_sel_q <= wr_data_i[1];
      end
    end
  end

  for (genvar k = 0; k < N_MSK; k++) begin : g_lvl
    localparam int WORD = k / PER_WORD;
    localparam int POS  = (k % PER_WORD) * LVL_W;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q[k] <= '0;
      else if (wr_en_i && wr_sel_i == SEL_W'(SEL_LVL0 + WORD))
        lvl_q[k] <= wr_data_i[POS +: LVL_W];
    end
    assign lvl_o[k*LVL_W +: LVL_W] = lvl_q[k];
  end

  assign en_o      = en_q;
  assign reloc_o   = reloc_q;
  assign wdt_sel_o = wdt_sel_q;
endmodule

// File: rtl/prio_vic_latch.sv
module prio_vic_latch #(
  parameter int N_SRC   = 25,
  parameter int WDT_IDX = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             wdt_sel_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] lat_o
);
  logic [N_SRC-1:0] set, lat_q;

  always_comb begin
    set = irq_i;
    // watchdog routed to reset does not pend
    if (wdt_sel_i) set[WDT_IDX] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else         lat_q <= (lat_q & ~clr_i) | set;
  end

  assign lat_o = lat_q;
endmodule

// File: rtl/prio_vic_arb.sv
module prio_vic_arb #(
  parameter int N_NMI  = 3,
  parameter int N_MSK  = 22,
  parameter int LVL_W  = 2,
  parameter int SRC_W  = 5,
  parameter int CEIL_W = 3
) (
  input  logic [N_NMI+N_MSK-1:0] lat_i,
  input  logic [N_MSK-1:0]       en_i,
  input  logic [N_MSK*LVL_W-1:0] lvl_i,
  input  logic                   imf_i,
  input  logic [CEIL_W-1:0]      ceil_i,
  input  logic                   full_i,
  output logic                   req_o,
  output logic [SRC_W-1:0]       src_o,
  output logic [CEIL_W-1:0]      ceil_o
);
  localparam int CEIL_NMI = (1 << LVL_W) + 1;

  logic [N_MSK-1:0] elig;
  logic             m_found, n_found;
  logic [LVL_W-1:0] best;

  for (genvar k = 0; k < N_MSK; k++) begin : g_elig
    assign elig[k] = lat_i[N_NMI+k] & en_i[k] & imf_i &
                     ((CEIL_W'(lvl_i[k*LVL_W +: LVL_W]) + CEIL_W'(1)) > ceil_i);
  end

  always_comb begin
    m_found = 1'b0;
    n_found = 1'b0;
    best    = '0;
    src_o   = '0;
    ceil_o  = '0;
    // descending scan with >= keeps the lowest index on equal level
    for (int k = N_MSK - 1; k >= 0; k--) begin
      if (elig[k] && (!m_found || lvl_i[k*LVL_W +: LVL_W] >= best)) begin
        m_found = 1'b1;
        best    = lvl_i[k*LVL_W +: LVL_W];
        src_o   = SRC_W'(N_NMI + k);
        ceil_o  = CEIL_W'(lvl_i[k*LVL_W +: LVL_W]) + CEIL_W'(1);
      end
    end
    for (int i = N_NMI - 1; i >= 0; i--) begin
      if (lat_i[i]) begin
        n_found = 1'b1;
        src_o   = SRC_W'(i);
        ceil_o  = CEIL_W'(CEIL_NMI);
      end
    end
    req_o = (m_found | n_found) & ~full_i;
  end
endmodule

// File: rtl/prio_vic_nest.sv
module prio_vic_nest #(
  parameter int CEIL_W     = 3,
  parameter int NEST_DEPTH = 4,
  parameter int DEP_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [CEIL_W-1:0] win_ceil_i,
  input  logic              reti_i,
  input  logic              imf_we_i,
  input  logic              imf_wd_i,
  output logic              imf_o,
  output logic [CEIL_W-1:0] ceil_o,
  output logic [DEP_W-1:0]  depth_o,
  output logic              full_o
);
  logic [CEIL_W:0]     stk_q [NEST_DEPTH];
  logic                imf_q;
  logic [CEIL_W-1:0]   ceil_q;
  logic [DEP_W-1:0]    depth_q, top_idx;
  logic                pop;

  assign top_idx = depth_q - DEP_W'(1);
  assign pop     = reti_i && !take_i && depth_q != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imf_q   <= 1'b0;
      ceil_q  <= '0;
      depth_q <= '0;
      for (int i = 0; i < NEST_DEPTH; i++) stk_q[i] <= '0;
    end else if (take_i) begin
      stk_q[depth_q] <= {imf_q, ceil_q};
      depth_q        <= depth_q + DEP_W'(1);
      imf_q          <= 1'b0;
      ceil_q         <= win_ceil_i;
    end else if (pop) begin
      {imf_q, ceil_q} <= stk_q[top_idx];
      depth_q         <= top_idx;
    end else if (imf_we_i) begin
      imf_q <= imf_wd_i;
    end
  end

  assign imf_o   = imf_q;
  assign ceil_o  = ceil_q;
  assign depth_o = depth_q;
  assign full_o  = depth_q == DEP_W'(NEST_DEPTH);
endmodule

// File: rtl/prio_vic.sv
module prio_vic
  import prio_vic_pkg::*;
#(
  parameter int          N_NMI      = 3,
  parameter int          N_MSK      = 22,
  parameter int          LVL_W      = 2,
  parameter int          NEST_DEPTH = 4,
  parameter int          DATA_W     = 32,
  parameter int          SEL_W      = 3,
  parameter logic [15:0] VEC_TOP    = 16'hFFFE,
  parameter logic [7:0]  RAM_PAGE   = 8'h01
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [N_NMI+N_MSK-1:0]                irq_i,
  input  logic                                  wr_en_i,
  input  logic [SEL_W-1:0]                      wr_sel_i,
  input  logic [DATA_W-1:0]                     wr_data_i,
  input  logic                                  ack_i,
  input  logic                                  reti_i,
  output logic                                  irq_req_o,
  output logic [$clog2(N_NMI+N_MSK)-1:0]        irq_src_o,
  output logic [15:0]                           irq_vec_o,
  output logic                                  wdt_reset_o
);
  localparam int N_SRC    = N_NMI + N_MSK;
  localparam int SRC_W    = $clog2(N_SRC);
  localparam int WDT_IDX  = N_NMI - 1;
  localparam int CEIL_NMI = (1 << LVL_W) + 1;
  localparam int CEIL_W   = $clog2(CEIL_NMI + 1);
  localparam int DEP_W    = $clog2(NEST_DEPTH + 1);

  logic [N_MSK-1:0]       en;
  logic [N_MSK*LVL_W-1:0] lvl;
  logic                   reloc, wdt_sel;
  logic [N_SRC-1:0]       lat_q, clr;
  logic                   imf_q, full, take, req;
  logic [CEIL_W-1:0]      ceil_q, win_ceil;
  logic [DEP_W-1:0]       depth_q;
  logic [SRC_W-1:0]       src;
  vec_t                   vec_raw;
  int                     vec_off;

  prio_vic_regs #(.N_MSK(N_MSK), .LVL_W(LVL_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .en_o(en), .lvl_o(lvl), .reloc_o(reloc), .wdt_sel_o(wdt_sel)
  );

  prio_vic_latch #(.N_SRC(N_SRC), .WDT_IDX(WDT_IDX)) u_latch (
    .clk_i, .rst_ni, .irq_i, .wdt_sel_i(wdt_sel), .clr_i(clr), .lat_o(lat_q)
  );

  prio_vic_arb #(.N_NMI(N_NMI), .N_MSK(N_MSK), .LVL_W(LVL_W), .SRC_W(SRC_W),
                 .CEIL_W(CEIL_W)) u_arb (
    .lat_i(lat_q), .en_i(en), .lvl_i(lvl), .imf_i(imf_q), .ceil_i(ceil_q),
    .full_i(full), .req_o(req), .src_o(src), .ceil_o(win_ceil)
  );

  prio_vic_nest #(.CEIL_W(CEIL_W), .NEST_DEPTH(NEST_DEPTH), .DEP_W(DEP_W)) u_nest (
    .clk_i, .rst_ni, .take_i(take), .win_ceil_i(win_ceil), .reti_i,
    .imf_we_i(wr_en_i && wr_sel_i == SEL_W'(SEL_MASTER)), .imf_wd_i(wr_data_i[0]),
    .imf_o(imf_q), .ceil_o(ceil_q), .depth_o(depth_q), .full_o(full)
  );

  assign take = ack_i & req;
  assign clr  = take ? (N_SRC'(1) << src) : '0;

  always_comb begin
    if (int'(src) < N_NMI) vec_off = (int'(src) == WDT_IDX) ? 6 : 2;
    else                   vec_off = 8 + 2 * (int'(src) - N_NMI);
    vec_raw = VEC_TOP - 16'(vec_off);
  end

  assign irq_vec_o   = reloc ? {RAM_PAGE, vec_raw[7:0]} : vec_raw;
  assign irq_req_o   = req;
  assign irq_src_o   = src;
  assign wdt_reset_o = wdt_sel & irq_i[WDT_IDX];
endmodule

// File: rtl/prio_vic_chk.sv
module prio_vic_chk #(
  parameter int N_NMI      = 3,
  parameter int N_SRC      = 25,
  parameter int SRC_W      = 5,
  parameter int CEIL_W     = 3,
  parameter int CEIL_NMI   = 5,
  parameter int DEP_W      = 3,
  parameter int NEST_DEPTH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  irq_i,
  input logic              ack_i,
  input logic              reti_i,
  input logic              irq_req_o,
  input logic [SRC_W-1:0]  irq_src_o,
  input logic              wdt_reset_o,
  input logic [N_SRC-1:0]  lat_q,
  input logic              imf_q,
  input logic [CEIL_W-1:0] ceil_q,
  input logic [DEP_W-1:0]  depth_q
);
  logic msk_offer;
  assign msk_offer = irq_req_o && irq_src_o >= SRC_W'(N_NMI);

  a_r1_req_backed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> lat_q[irq_src_o]);

  a_r2_mask_needs_imf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msk_offer |-> imf_q);

  a_r4_nmi_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msk_offer |-> lat_q[N_NMI-1:0] == '0);

  a_r6_ack_clears_imf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_req_o) |=> !imf_q);

  a_r6_ack_clears_lat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_req_o && !irq_i[irq_src_o]) |=> !lat_q[$past(irq_src_o)]);

  a_r7_nmi_blocks_msk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msk_offer |-> ceil_q != CEIL_W'(CEIL_NMI));

  a_r8_pop_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !(ack_i && irq_req_o) && depth_q != '0) |=> depth_q == $past(depth_q) - DEP_W'(1));

  a_r9_wdt_no_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_reset_o && !lat_q[N_NMI-1]) |=> !lat_q[N_NMI-1]);

  a_r11_full_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_q == DEP_W'(NEST_DEPTH) |-> !irq_req_o);
endmodule

bind prio_vic prio_vic_chk #(
  .N_NMI(N_NMI), .N_SRC(N_SRC), .SRC_W(SRC_W), .CEIL_W(CEIL_W),
  .CEIL_NMI(CEIL_NMI), .DEP_W(DEP_W), .NEST_DEPTH(NEST_DEPTH)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .ack_i(ack_i), .reti_i(reti_i),
  .irq_req_o(irq_req_o), .irq_src_o(irq_src_o), .wdt_reset_o(wdt_reset_o),
  .lat_q(lat_q), .imf_q(imf_q), .ceil_q(ceil_q), .depth_q(depth_q)
);

// File: tb/sim_prio_vic.sv
module sim_prio_vic;
  localparam int CLK_PERIOD = 10;
  localparam int NN = 3;
  localparam int NM = 22;
  localparam int NS = 25;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [24:0] irq = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        ack = 1'b0, reti = 1'b0;
  logic        req, wdt_rst;
  logic [4:0]  src;
  logic [15:0] vec;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_vic u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .ack_i(ack), .reti_i(reti), .irq_req_o(req),
    .irq_src_o(src), .irq_vec_o(vec), .wdt_reset_o(wdt_rst)
  );

  // behavioural reference model
  bit m_lat[NS];
  bit m_en[NM];
  int m_lvl[NM];
  bit m_imf, m_reloc, m_wsel;
  int m_ceil;
  int m_stk_imf[$];
  int m_stk_ceil[$];

  function automatic void m_pick(output bit r, output int s);
    int best;
    r = 0; s = 0; best = -1;
    if (m_stk_imf.size() >= 4) return;
    for (int i = 0; i < NN; i++) if (m_lat[i]) begin r = 1; s = i; return; end
    for (int k = 0; k < NM; k++)
      if (m_lat[NN+k] && m_en[k] && m_imf && m_lvl[k] + 1 > m_ceil && m_lvl[k] > best) begin
        best = m_lvl[k]; r = 1; s = NN + k;
      end
  endfunction

  function automatic int m_vec(int s);
    int v;
    if (s < 2) v = 'hFFFC;
    else if (s == 2) v = 'hFFF8;
    else v = 'hFFF6 - 2 * (s - 3);
    if (m_reloc) v = 'h0100 | (v & 'hFF);
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit r; int s; bit ws;
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) m_lat[i] = 0;
      for (int k = 0; k < NM; k++) begin m_en[k] = 0; m_lvl[k] = 0; end
      m_imf = 0; m_reloc = 0; m_wsel = 1; m_ceil = 0;
      m_stk_imf.delete(); m_stk_ceil.delete();
    end else begin
      m_pick(r, s);
      ws = m_wsel;
      if (ack && r) begin
        m_stk_imf.push_back(m_imf); m_stk_ceil.push_back(m_ceil);
        m_imf = 0; m_ceil = (s < NN) ? 5 : m_lvl[s-NN] + 1; m_lat[s] = 0;
      end else if (reti && m_stk_imf.size() > 0) begin
        m_imf = m_stk_imf.pop_back(); m_ceil = m_stk_ceil.pop_back();
      end else if (wr_en && wr_sel == 0) m_imf = wr_data[0];
      if (wr_en) begin
        case (wr_sel)
          3'd1: for (int k = 0; k < NM; k++) m_en[k] = wr_data[k];
          3'd2: for (int k = 0; k < 16; k++) m_lvl[k] = (wr_data >> (2*k)) & 3;
          3'd3: for (int k = 16; k < NM; k++) m_lvl[k] = (wr_data >> (2*(k-16))) & 3;
          3'd4: begin m_reloc = wr_data[0]; m_wsel = wr_data[1]; end
          default: ;
        endcase
      end
      for (int i = 0; i < NS; i++) if (irq[i] && !(i == 2 && ws)) m_lat[i] = 1;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    bit r; int s;
    if (rst_n && !done) begin
      m_pick(r, s);
      checks++;
      if (req !== r || (r && (src !== 5'(s) || vec !== 16'(m_vec(s)))) || wdt_rst !== (irq[2] & m_wsel)) begin
        errors++;
        $display("FAIL R1 R2 R3 R4 R5 R6 R7 R8 R9 R11 model: act req=%0b src=%0d vec=%h wdt=%0b exp req=%0b src=%0d vec=%h wdt=%0b",
                 req, src, vec, wdt_rst, r, s, 16'(m_vec(s)), irq[2] & m_wsel);
      end
    end
  end

  task automatic finish_run;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      errors++;
      $display("FAIL R10 watchdog: act=running exp=finished");
      finish_run();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc; @(posedge clk); #1; endtask
  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_data = d; cyc(); wr_en = 0;
  endtask
  task automatic pulse(input logic [24:0] m); irq = m; cyc(); irq = '0; endtask
  task automatic do_ack; ack = 1; cyc(); ack = 0; endtask
  task automatic do_reti; reti = 1; cyc(); reti = 0; endtask

  localparam logic [31:0] LVL_A = (32'd2 << 10) | (32'd2 << 18) | (32'd1 << 2);

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 req in reset", req, 0);
    chk("R10 wdt_reset in reset", wdt_rst, 0);
    rst_n = 1; cyc();
    chk("R10 req after reset", req, 0);

    irq = 25'h4; #1;
    chk("R9 wdt routed to reset", wdt_rst, 1);
    cyc(); irq = '0;
    chk("R9 wdt not latched", req, 0);

    pulse(25'h8);
    chk("R2 masked by enables", req, 0);
    wr(3'd1, 32'h1);
    chk("R2 masked by master enable", req, 0);
    wr(3'd0, 32'h1);
    chk("R2 offered when enabled", req, 1);
    chk("R1 latched source", src, 3);
    chk("R5 first maskable vector", vec, 16'hFFF6);

    wr(3'd1, 32'h3FFFFF);
    wr(3'd2, LVL_A);
    pulse((25'd1 << 8) | (25'd1 << 12) | (25'd1 << 4));
    chk("R3 level then index winner", src, 8);
    chk("R5 vector of src 8", vec, 16'hFFEC);

    do_ack();
    chk("R6 ack clears master enable", req, 0);
    wr(3'd0, 32'h1);
    chk("R7 equal or lower level blocked", req, 0);
    wr(3'd2, LVL_A | 32'h3);
    chk("R7 higher level nests", src, 3);
    chk("R7 higher level offered", req, 1);

    do_ack();
    do_reti();
    chk("R8 first return restores level 2", req, 0);
    do_reti();
    chk("R8 second return restores idle", req, 1);
    chk("R8 winner after return", src, 12);
    chk("R5 vector of src 12", vec, 16'hFFE4);

    wr(3'd0, 32'h0);
    chk("R2 master enable off", req, 0);
    pulse(25'h2);
    chk("R4 nmi ignores master enable", src, 1);
    chk("R5 illegal-opcode vector", vec, 16'hFFFC);
    pulse(25'h1);
    chk("R4 lowest nmi first", src, 0);
    do_ack();
    chk("R4 nmi nests over nmi", src, 1);
    do_ack();
    chk("R4 no maskable while masked", req, 0);

    wr(3'd4, 32'h1);
    irq = 25'h4; #1;
    chk("R9 wdt not routed when cleared", wdt_rst, 0);
    cyc(); irq = '0;
    chk("R9 wdt latched as nmi", src, 2);
    chk("R5 relocated wdt vector", vec, 16'h01F8);
    do_ack();
    pulse(25'h1);
    chk("R5 relocated shared vector", vec, 16'h01FC);
    do_ack();
    pulse(25'h2);
    chk("R11 full stack offers nothing", req, 0);
    do_reti();
    chk("R11 offer after return", src, 1);
    irq = 25'h2; ack = 1; cyc(); irq = '0; ack = 0;
    chk("R6 full again after ack", req, 0);
    do_reti();
    chk("R6 same-cycle request kept", req, 1);
    chk("R6 same-cycle source", src, 1);

    repeat (3) cyc();
    finish_run();
  end
endmodule